// File: doc/BRIEF.md
# Priority Bus Arbiter with Parking and Ageing

This block arbitrates a shared synchronous bus between a fixed number of masters. Each master has its own request, grant and release lines. The arbiter registers one owner at a time. Among the masters that are waiting, a lower index ranks higher. A per-master wait counter promotes any master that has waited too long above every fixed rank, so no master is kept off the bus for ever.

The candidate for the next owner is chosen combinationally from the requests of the same cycle. When the owner releases, the grant moves at that edge. No cycle is spent on arbitration between two owners. If no other master is asking, the grant stays with the current owner (parking), and that owner can start another transfer at once. An owner that has parked and is not requesting also gives up the bus when the bus is idle and someone else asks.

Top module: `bus_arb_park`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `gnt` is all zeros.
- R2: At most one bit of `gnt` is high in any cycle.
- R3: With no grant held, the arbiter acts at the next edge. If any request is present, it grants the winner. Otherwise, if `bus_idle` is high, it parks the grant on master 0 (`gnt` = 1). Otherwise it stays ungranted. Once a grant is held, `gnt` is never zero again until reset.
- R4: Among eligible requesters that are not promoted, the lowest index wins.
- R5: Each master has a wait counter of `AGE_W` bits. At every edge the counter adds one, saturating at all ones, if the master requests without holding the grant. Otherwise it clears. A master whose counter is greater than or equal to `starve_limit` is promoted, and promoted masters beat all others. Among promoted masters, the lowest index wins.
- R6: If the owner's `done` bit is high at an edge and another master requests, `gnt` moves to the winner at that edge. The new owner's grant is visible in the cycle right after the release.
- R7: If `bus_idle` is high, the owner's request is low and another master requests, `gnt` moves to the winner at that edge.
- R8: While no master other than the owner requests, the grant stays with the owner. This holds even across its `done` pulses, so transfers can run back to back.
- R9: When neither hand-over condition of R6 or R7 holds, the owner keeps the grant. A `done` bit from a master that is not the owner has no effect.
- R10: The current owner is never chosen as the winner of a hand-over. The new owner is always a master that was requesting at the hand-over edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req | input | NUM_M | Per-master bus request |
| done | input | NUM_M | Per-master release pulse; only the owner's bit is used |
| bus_idle | input | 1 | High when no transfer is running on the bus |
| starve_limit | input | AGE_W | Wait count at which a master is promoted |
| gnt | output | NUM_M | Registered one-hot grant, zero only before the first grant |

## Verification
The properties assume that `req`, `done` and `bus_idle` are known values that change only between clock edges. They assume nothing about protocol: requests may drop before a grant, and any master may pulse `done`. The bench keeps to these assumptions by driving every input on the falling edge. It draws requests, release pulses and idle flags from a seeded random stream with different biases and several promotion limits. It also lets non-owners pulse `done`, so that the rule that only the owner can release is exercised.

// File: rtl/busarb_pkg.sv
package busarb_pkg;

    // Why the grant may change at an edge
    typedef enum logic [1:0] {
        MOVE_NONE  = 2'd0,
        MOVE_FIRST = 2'd1,
        MOVE_DONE  = 2'd2,
        MOVE_IDLE  = 2'd3
    } move_e;

    typedef struct packed {
        logic held;
        logic [7:0] owner;
    } own_s;

    // saturating increment of a wait count
    function automatic logic [15:0] sat_inc(input logic [15:0] v, input logic [15:0] top);
        return (v >= top) ? top : v + 16'd1;
    endfunction

endpackage

// File: rtl/arb_age.sv
module arb_age #(
    parameter int AGE_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             waiting,
    input  logic [AGE_W-1:0] limit,
    output logic             ripe
);
    import busarb_pkg::*;

    localparam logic [15:0] TOP = 16'((1 << AGE_W) - 1);

    logic [AGE_W-1:0] age_q;
    logic [15:0]      wide_nxt;

    always_comb begin
        wide_nxt = sat_inc(16'(age_q), TOP);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            age_q <= '0;
        end else if (waiting) begin
            age_q <= wide_nxt[AGE_W-1:0];
        end else begin
            age_q <= '0;
        end
    end

    assign ripe = (age_q >= limit);
endmodule

// File: rtl/arb_pick.sv
module arb_pick #(
    parameter int NUM_M = 4,
    parameter int IW    = 2
) (
    input  logic [NUM_M-1:0] cand,
    input  logic [NUM_M-1:0] promoted,
    output logic             found,
    output logic [IW-1:0]    idx
);
    logic [NUM_M-1:0] urgent;
    logic [NUM_M-1:0] pool;

    always_comb begin
        urgent = cand & promoted;
        pool   = (urgent != '0) ? urgent : cand;
        found  = (cand != '0);
        idx    = '0;
        for (int i = NUM_M - 1; i >= 0; i--) begin
            if (pool[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/bus_arb_park.sv
module bus_arb_park #(
    parameter int NUM_M = 4,
    parameter int AGE_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NUM_M-1:0] req,
    input  logic [NUM_M-1:0] done,
    input  logic             bus_idle,
    input  logic [AGE_W-1:0] starve_limit,
    output logic [NUM_M-1:0] gnt
);
    import busarb_pkg::*;

    localparam int IW = (NUM_M > 1) ? $clog2(NUM_M) : 1;

    logic             held_q;
    logic [IW-1:0]    owner_q;
    logic [NUM_M-1:0] own_mask;
    logic [NUM_M-1:0] eligible;
    logic [NUM_M-1:0] ripe;
    logic [NUM_M-1:0] waiting;
    logic             found;
    logic [IW-1:0]    win_idx;
    move_e            move;

    always_comb begin
        own_mask = '0;
        if (held_q) own_mask[owner_q] = 1'b1;
    end

    assign gnt      = own_mask;
    assign eligible = req & ~own_mask;
    assign waiting  = req & ~own_mask;

    generate
        for (genvar g = 0; g < NUM_M; g++) begin : g_age
            arb_age #(.AGE_W(AGE_W)) u_age (
                .clk     (clk),
                .rst     (rst),
                .waiting (waiting[g]),
                .limit   (starve_limit),
                .ripe    (ripe[g])
            );
        end
    endgenerate

    arb_pick #(.NUM_M(NUM_M), .IW(IW)) u_pick (
        .cand     (eligible),
        .promoted (ripe),
        .found    (found),
        .idx      (win_idx)
    );

    always_comb begin
        move = MOVE_NONE;
        if (!held_q) begin
            move = MOVE_FIRST;
        end else if (found) begin
            if (done[owner_q])                  move = MOVE_DONE;
            else if (bus_idle && !req[owner_q]) move = MOVE_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q  <= 1'b0;
            owner_q <= '0;
        end else begin
            case (move)
                MOVE_FIRST: begin
                    if (found) begin
                        held_q  <= 1'b1;
                        owner_q <= win_idx;
                    end else if (bus_idle) begin
                        held_q  <= 1'b1;
                        owner_q <= '0;
                    end
                end
                MOVE_DONE, MOVE_IDLE: owner_q <= win_idx;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/bus_arb_park_chk.sv
module bus_arb_park_chk #(
    parameter int NUM_M = 4,
    parameter int AGE_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic [NUM_M-1:0] req,
    input logic [NUM_M-1:0] done,
    input logic             bus_idle,
    input logic [NUM_M-1:0] gnt
);
    p_onehot_r2: assert property (@(posedge clk) disable iff (rst) $onehot0(gnt));

    p_sticky_r3: assert property (@(posedge clk) disable iff (rst)
        (gnt != '0) |=> (gnt != '0));

    p_firstpark_r3: assert property (@(posedge clk) disable iff (rst)
        (gnt == '0 && req == '0 && bus_idle) |=> (gnt == NUM_M'(1)));

    p_park_r8: assert property (@(posedge clk) disable iff (rst)
        (gnt != '0 && (req & ~gnt) == '0) |=> (gnt == $past(gnt)));

    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (gnt != '0 && (done & gnt) == '0 && !(bus_idle && (req & gnt) == '0))
        |=> (gnt == $past(gnt)));

    p_handover_r10: assert property (@(posedge clk) disable iff (rst)
        (gnt != '0 && (req & ~gnt) != '0 &&
         ((done & gnt) != '0 || (bus_idle && (req & gnt) == '0)))
        |=> (gnt != $past(gnt)) && ((gnt & $past(req)) != '0));
endmodule

bind bus_arb_park bus_arb_park_chk #(.NUM_M(NUM_M), .AGE_W(AGE_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .req      (req),
    .done     (done),
    .bus_idle (bus_idle),
    .gnt      (gnt)
);

// File: tb/bus_arb_park_tb.sv
module bus_arb_park_tb;
    localparam int N  = 4;
    localparam int AW = 4;
    localparam int AGE_MAX = (1 << AW) - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  req = '0;
    logic [N-1:0]  done = '0;
    logic          bus_idle = 1'b0;
    logic [AW-1:0] starve_limit = AW'(AGE_MAX);
    logic [N-1:0]  gnt;

    int n_chk  = 0;
    int n_fail = 0;

    // model state
    bit m_held = 0;
    int m_owner = 0;
    int m_age[N];
    string m_tag = "R1";

    always #2.5 clk = ~clk;

    bus_arb_park #(.NUM_M(N), .AGE_W(AW)) u_dut (
        .clk(clk), .rst(rst), .req(req), .done(done),
        .bus_idle(bus_idle), .starve_limit(starve_limit), .gnt(gnt)
    );

    function automatic logic [N-1:0] exp_gnt();
        logic [N-1:0] v = '0;
        if (m_held) v[m_owner] = 1'b1;
        return v;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [N-1:0] act, input logic [N-1:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: gnt actual %b expected %b", tag, act, expv);
        end
    endtask

    // advance the model by one edge using the inputs currently applied
    task automatic model_step();
        logic [N-1:0] elig, urg, pool;
        int win;
        bit fnd;
        elig = req;
        if (m_held) elig[m_owner] = 1'b0;
        urg = '0;
        for (int i = 0; i < N; i++) if (elig[i] && m_age[i] >= int'(starve_limit)) urg[i] = 1'b1;
        pool = (urg != '0) ? urg : elig;
        win = 0;
        for (int i = N - 1; i >= 0; i--) if (pool[i]) win = i;
        fnd = (elig != '0);
        for (int i = 0; i < N; i++) begin
            if (elig[i]) m_age[i] = (m_age[i] >= AGE_MAX) ? AGE_MAX : m_age[i] + 1;
            else         m_age[i] = 0;
        end
        if (!m_held) begin
            m_tag = (urg != '0) ? "R3 R5" : "R3 R4";
            if (fnd) begin m_held = 1; m_owner = win; end
            else if (bus_idle) begin m_held = 1; m_owner = 0; end
        end else if (!fnd) begin
            m_tag = "R8";
        end else if (done[m_owner]) begin
            m_tag = (urg != '0) ? "R6 R5" : "R6 R4";
            m_owner = win;
        end else if (bus_idle && !req[m_owner]) begin
            m_tag = (urg != '0) ? "R7 R5" : "R7 R4";
            m_owner = win;
        end else begin
            m_tag = "R9";
        end
    endtask

    task automatic cycle(input logic [N-1:0] r, input logic [N-1:0] d, input logic idl);
        req = r; done = d; bus_idle = idl;
        model_step();
        @(negedge clk);
        check(gnt == exp_gnt(), m_tag, gnt, exp_gnt());
    endtask

    task automatic rand_phase(input int cycles, input int req_pct, input int done_pct, input int lim);
        starve_limit = AW'(lim);
        for (int c = 0; c < cycles; c++) begin
            logic [N-1:0] r, d;
            for (int i = 0; i < N; i++) begin
                r[i] = ($urandom % 100) < req_pct;
                d[i] = ($urandom % 100) < done_pct;
            end
            cycle(r, d, 1'($urandom % 2));
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        int waited;
        void'($urandom(32'd20240611));
        for (int i = 0; i < N; i++) m_age[i] = 0;
        // R1: reset holds grant low even with activity
        req = 4'b1111; bus_idle = 1'b1;
        repeat (3) @(negedge clk);
        check(gnt == '0, "R1", gnt, '0);
        req = '0; bus_idle = 1'b0;
        rst = 1'b0;
        check(gnt == '0, "R1", gnt, '0);
        // R3: no request, bus busy -> still ungranted
        cycle('0, '0, 1'b0);
        cycle('0, '0, 1'b0);
        check(gnt == '0, "R3 no grant while busy", gnt, '0);
        // R3: idle -> park on master 0
        cycle('0, '0, 1'b1);
        check(gnt == 4'b0001, "R3 park on 0", gnt, 4'b0001);
        // R9: done from a non-owner has no effect
        starve_limit = AW'(AGE_MAX);
        cycle(4'b0100, 4'b0100, 1'b0);
        check(gnt == 4'b0001, "R9 stray done", gnt, 4'b0001);
        // R6 R4: owner releases, 1 and 3 wait -> 1
        cycle(4'b1010, 4'b0001, 1'b0);
        check(gnt == 4'b0010, "R6 R4 hand-over", gnt, 4'b0010);
        // R8: owner alone, back-to-back done keeps grant
        cycle(4'b0010, 4'b0010, 1'b0);
        cycle(4'b0010, 4'b0010, 1'b1);
        check(gnt == 4'b0010, "R8 parked owner", gnt, 4'b0010);
        // R7: owner idle and not asking, master 2 asks
        cycle(4'b0100, '0, 1'b1);
        check(gnt == 4'b0100, "R7 idle hand-over", gnt, 4'b0100);
        // R5: masters 0,1 trade the bus; 3 must be promoted
        starve_limit = AW'(3);
        waited = 0;
        while (gnt[3] !== 1'b1 && waited < 30) begin
            cycle(4'b1011, gnt, 1'b0);
            waited++;
        end
        check(gnt[3] === 1'b1 && waited <= 8, "R5 promotion of master 3", gnt, 4'b1000);
        // random phases with different promotion limits
        rand_phase(3000, 50, 30, AGE_MAX);
        rand_phase(3000, 70, 40, 2);
        rand_phase(3000, 30, 20, 0);
        rand_phase(3000, 90, 60, 5);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule